// File: doc/BRIEF.md
# Multi-Sector Erase Queue Timer

This block gathers sector erase requests for a flash array that is divided into eight sectors. The command decoder recognises the full six-write erase command sequence and signals it with a pulse. The block then opens a collection window and marks the addressed sector in a pending mask. Every further erase-code write (30H) that lands inside the window adds its sector to the mask and restarts the window. A write that carries any other data code throws the whole batch away and sends the device back to read mode.

When no write has arrived for a full window, the block hands the mask to the erase engine with a one-cycle start pulse. It then holds its busy status until the engine reports completion. Sectors whose protect bit is set are never queued. A batch that ends up empty starts nothing and simply closes.

Top module: `sect_erase_queue`

## Requirements
- R1: After a synchronous active-low reset, the pending mask is 0, both status bits are 0 and both pulse outputs are 0.
- R2: The sector number is address bits 16:14, and sector n is held in bit n of the pending mask.
- R3: While idle, the window opens only on a write strobe that carries data 30H and coincides with the sequence-complete pulse. Any other write leaves the block idle with an empty mask.
- R4: While the window is open, each write of 30H sets the bit of its sector in the mask. Sectors may arrive in any order, repeats are harmless, and all eight may be queued.
- R5: Every write inside the window restarts it. The window expires WIN_CYCLES clock edges after the edge that took the last write. A write on the expiry edge itself restarts the window instead of expiring it.
- R6: On expiry with a non-empty mask, erase_start is high for exactly one cycle, erase_begun rises in the same cycle, win_open falls, and the mask is kept.
- R7: A write with data other than 30H inside the window raises abort_rd for one cycle, clears the mask and closes the window.
- R8: A write aimed at a protected sector leaves the mask unchanged. If the mask is empty at expiry, no start pulse is issued and the block returns to idle.
- R9: While erase_begun is 1, every write is ignored and the mask stays stable. The erase_done input clears the mask and returns the block to idle.
- R10: win_open is 1 exactly while the collection window is running, and it is never 1 at the same time as erase_begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 17 | Write address; the top three bits pick the sector |
| wr_data | input | 8 | Write data code |
| seq_done | input | 1 | Decoder pulse: this write completes the erase command sequence |
| prot_mask | input | 8 | Per-sector protect bits, 1 = protected |
| erase_done | input | 1 | Erase engine has finished the batch |
| pend_mask | output | 8 | Sectors queued for erase |
| erase_start | output | 1 | One-cycle pulse that hands pend_mask to the erase engine |
| abort_rd | output | 1 | One-cycle pulse: batch discarded, back to read mode |
| win_open | output | 1 | Collection window running |
| erase_begun | output | 1 | Erase under way; writes are ignored |

## Verification
The bench builds the block with WIN_CYCLES set to 12 in place of the default 4000. This puts window expiry, repeated restarts and a write on the exact expiry edge within a few dozen cycles. Random traffic then drives the idle, collecting and busy states many times over a few thousand cycles. The protect mask changes between runs, so both partly filled and empty batches occur.

// File: rtl/seq_pkg.sv
// Package: shared state encoding for the sector erase queue.
// Assumes: three control states are enough; no other block decodes them.
package seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_OPEN = 2'd1,
        SQ_BUSY = 2'd2
    } sq_state_t;
endpackage

// File: rtl/seq_sector_map.sv
// Module: seq_sector_map
// Converts the sector field of a write address into a one-hot sector vector
// and reports whether that sector is free of protection.
// Assumes: the sector field is the top SECT_BITS of the address.
module seq_sector_map #(
    parameter int SECT_BITS = 3,
    localparam int NSECT = 1 << SECT_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SECT_BITS-1:0] sect_field,
    input  logic [NSECT-1:0]     prot_mask,
    output logic [NSECT-1:0]     sect_hot,
    output logic                 sect_ok
);
    // one comparator per sector produces the one-hot vector
    for (genvar g = 0; g < NSECT; g++) begin : g_dec
        assign sect_hot[g] = (sect_field == SECT_BITS'(g));
    end

    // a sector may join only when its protect bit is clear
    assign sect_ok = ~|(sect_hot & prot_mask);

    // R2: exactly one sector is selected for any address
    a_r2_one_sector: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sect_hot) == 1);
endmodule

// File: rtl/seq_win_timer.sv
// Module: seq_win_timer
// Inactivity window counter. A load restarts the full window, and the
// counter runs down while the window is active. It flags expiry on the
// edge after it has reached zero, unless a load arrives on that edge.
// Assumes: WIN_CYCLES >= 1, and load is only asserted when a write is taken.
module seq_win_timer #(
    parameter int WIN_CYCLES = 4000,
    localparam int CNT_W = $clog2(WIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic load,
    output logic expired
);
    logic [CNT_W-1:0] cnt_q;

    // reload on every accepted write, otherwise count down while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(WIN_CYCLES - 1);
        end else if (active && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // expiry: window running, counter drained, no restart this cycle
    assign expired = active && !load && (cnt_q == '0);

    // R5: a restart always wins over expiry
    a_r5_load_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !expired);

    // R5: after a reload the window cannot expire on the very next edge
    // unless the window is a single cycle long
    a_r5_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (load && WIN_CYCLES > 1) |=> !expired);
endmodule

// File: rtl/sect_erase_queue.sv
// Module: sect_erase_queue
// Collects sector erase requests into a pending mask during a restartable
// inactivity window, then starts the erase engine with that mask.
// A foreign data code inside the window aborts the batch.
// Assumes: seq_done coincides with the wr_stb of the final write of the
// six-write erase sequence; erase_done is a pulse from the erase engine.
module sect_erase_queue #(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int SECT_BITS  = 3,
    parameter int WIN_CYCLES = 4000,
    parameter logic [7:0] ERASE_CODE = 8'h30,
    localparam int NSECT = 1 << SECT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              seq_done,
    input  logic [NSECT-1:0]  prot_mask,
    input  logic              erase_done,
    output logic [NSECT-1:0]  pend_mask,
    output logic              erase_start,
    output logic              abort_rd,
    output logic              win_open,
    output logic              erase_begun
);
    import seq_pkg::*;

    sq_state_t        state_q;
    logic [NSECT-1:0] mask_q;
    logic             start_q;
    logic             abort_q;
    logic [NSECT-1:0] sect_hot;
    logic             sect_ok;
    logic             is_code;
    logic             first_take;
    logic             more_take;
    logic             foreign;
    logic             win_load;
    logic             win_exp;
    logic [NSECT-1:0] add_bits;
    logic             unused_addr;

    assign unused_addr = ^wr_addr[ADDR_W-SECT_BITS-1:0];

    seq_sector_map #(.SECT_BITS(SECT_BITS)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .sect_field (wr_addr[ADDR_W-1 -: SECT_BITS]),
        .prot_mask  (prot_mask),
        .sect_hot   (sect_hot),
        .sect_ok    (sect_ok)
    );

    // classify the current write against the control state
    always_comb begin
        is_code    = (wr_data == DATA_W'(ERASE_CODE));
        first_take = (state_q == SQ_IDLE) && wr_stb && seq_done && is_code;
        more_take  = (state_q == SQ_OPEN) && wr_stb && is_code;
        foreign    = (state_q == SQ_OPEN) && wr_stb && !is_code;
        win_load   = first_take || more_take;
        add_bits   = sect_ok ? sect_hot : '0;
    end

    seq_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == SQ_OPEN),
        .load    (win_load),
        .expired (win_exp)
    );

    // control state, pending mask and registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            mask_q  <= '0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            abort_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (first_take) begin
                        state_q <= SQ_OPEN;
                        mask_q  <= add_bits;
                    end
                end
                SQ_OPEN: begin
                    if (foreign) begin
                        state_q <= SQ_IDLE;
                        mask_q  <= '0;
                        abort_q <= 1'b1;
                    end else if (more_take) begin
                        mask_q <= mask_q | add_bits;
                    end else if (win_exp) begin
                        if (mask_q != '0) begin
                            state_q <= SQ_BUSY;
                            start_q <= 1'b1;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                SQ_BUSY: begin
                    if (erase_done) begin
                        state_q <= SQ_IDLE;
                        mask_q  <= '0;
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                    mask_q  <= '0;
                end
            endcase
        end
    end

    // outputs straight from registers
    assign pend_mask   = mask_q;
    assign erase_start = start_q;
    assign abort_rd    = abort_q;
    assign win_open    = (state_q == SQ_OPEN);
    assign erase_begun = (state_q == SQ_BUSY);

    // R6: start is a single-cycle pulse with a non-empty mask
    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);
    a_r6_start_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (pend_mask != '0) && erase_begun);

    // R7: an abort leaves an empty mask and a closed window
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_rd |-> (pend_mask == '0) && !win_open && !erase_begun);

    // R9: writes cannot disturb a running erase
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_begun && !erase_done) |=> erase_begun && $stable(pend_mask));

    // R10: the two status bits are exclusive
    a_r10_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_open && erase_begun));

    // R4: while collecting without a foreign write, queued sectors never drop
    a_r4_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !(wr_stb && wr_data != DATA_W'(ERASE_CODE)))
        |=> ((pend_mask & $past(pend_mask)) == $past(pend_mask)));

    // R3: idle never turns into busy without passing through the window
    a_r3_idle_path: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !erase_begun) |=> !erase_begun);
endmodule

// File: tb/sect_erase_queue_tb_top.sv
module sect_erase_queue_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_stb;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    logic        seq_done;
    logic [7:0]  prot_mask;
    logic        erase_done;
    logic [7:0]  pend_mask;
    logic        erase_start;
    logic        abort_rd;
    logic        win_open;
    logic        erase_begun;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit finished = 0;

    // reference model state (0 idle, 1 open, 2 busy)
    int       m_st;
    int       m_cnt;
    bit [7:0] m_mask;
    bit       m_start;
    bit       m_abort;

    always #(CLK_PERIOD/2) clk = ~clk;

    sect_erase_queue #(.WIN_CYCLES(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .seq_done(seq_done), .prot_mask(prot_mask),
        .erase_done(erase_done), .pend_mask(pend_mask),
        .erase_start(erase_start), .abort_rd(abort_rd),
        .win_open(win_open), .erase_begun(erase_begun)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected next state from the requirements, applied to current inputs
    task automatic model_step();
        bit [7:0] bitv;
        bit       okp;
        bitv = 8'd1 << wr_addr[16:14];
        okp  = !prot_mask[wr_addr[16:14]];
        m_start = 0;
        m_abort = 0;
        case (m_st)
            0: if (wr_stb && seq_done && wr_data == 8'h30) begin
                   m_st = 1; m_cnt = WIN - 1; m_mask = okp ? bitv : 8'h00;
               end
            1: if (wr_stb) begin
                   if (wr_data == 8'h30) begin
                       m_mask = m_mask | (okp ? bitv : 8'h00); m_cnt = WIN - 1;
                   end else begin
                       m_abort = 1; m_mask = 0; m_st = 0;
                   end
               end else if (m_cnt == 0) begin
                   if (m_mask != 0) begin m_st = 2; m_start = 1; end
                   else m_st = 0;
               end else m_cnt--;
            default: if (erase_done) begin m_st = 0; m_mask = 0; end
        endcase
    endtask

    // one clock: model, edge, compare, release strobes
    task automatic tick();
        model_step();
        @(negedge clk);
        check("R4 pend_mask", pend_mask, m_mask);
        check("R5 erase_start", erase_start, m_start);
        check("R7 abort_rd", abort_rd, m_abort);
        check("R10 win_open", win_open, m_st == 1);
        check("R9 erase_begun", erase_begun, m_st == 2);
        wr_stb = 0; seq_done = 0; erase_done = 0;
    endtask

    task automatic wr(input int sect, input bit [7:0] d, input bit sq);
        wr_stb = 1; seq_done = sq; wr_data = d;
        wr_addr = {sect[2:0], 14'($urandom)};
    endtask

    task automatic finish_erase();
        while (!erase_begun) tick();
        erase_done = 1; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC7_0A11));
        rst_n = 0; wr_stb = 0; wr_addr = 0; wr_data = 0; seq_done = 0;
        prot_mask = 0; erase_done = 0;
        m_st = 0; m_cnt = 0; m_mask = 0; m_start = 0; m_abort = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 mask", pend_mask, 0);
        check("R1 win_open", win_open, 0);
        check("R1 erase_begun", erase_begun, 0);
        check("R1 pulses", {erase_start, abort_rd}, 0);

        // R3: idle writes without the sequence pulse or with a wrong code
        wr(4, 8'h30, 0); tick();
        check("R3 no open without seq", win_open, 0);
        wr(4, 8'h80, 1); tick();
        check("R3 no open wrong code", win_open, 0);
        check("R3 mask empty", pend_mask, 0);

        // R2/R4/R5/R6: three sectors, expiry, start pulse
        wr(5, 8'h30, 1); tick();
        check("R2 sector five bit", pend_mask, 8'h20);
        wr(0, 8'h30, 0); tick();
        wr(7, 8'h30, 0); tick();
        check("R4 three sectors", pend_mask, 8'hA1);
        for (int i = 0; i < WIN - 1; i++) tick();
        check("R5 still open before expiry", win_open, 1);
        check("R5 no start yet", erase_start, 0);
        tick();
        check("R6 start pulse", erase_start, 1);
        check("R6 begun", erase_begun, 1);
        check("R6 window closed", win_open, 0);
        check("R6 mask kept", pend_mask, 8'hA1);
        tick();
        check("R6 single cycle", erase_start, 0);
        // R9: writes ignored while busy
        wr(2, 8'h30, 1); tick();
        check("R9 busy write ignored", pend_mask, 8'hA1);
        wr(2, 8'hF0, 0); tick();
        check("R9 busy foreign ignored", abort_rd, 0);
        erase_done = 1; tick();
        check("R9 done clears mask", pend_mask, 0);
        check("R9 done idle", erase_begun, 0);

        // R5: write on the exact expiry edge restarts the window
        wr(1, 8'h30, 1); tick();
        for (int i = 0; i < WIN - 1; i++) tick();
        wr(6, 8'h30, 0); tick();
        check("R5 restart on expiry edge", win_open, 1);
        check("R5 restart no start", erase_start, 0);
        check("R5 restart mask", pend_mask, 8'h42);
        for (int i = 0; i < WIN - 1; i++) tick();
        tick();
        check("R5 later expiry", erase_start, 1);
        erase_done = 1; tick();

        // R7: foreign code aborts
        wr(3, 8'h30, 1); tick();
        wr(3, 8'hF0, 0); tick();
        check("R7 abort pulse", abort_rd, 1);
        check("R7 mask cleared", pend_mask, 0);
        check("R7 window closed", win_open, 0);
        tick();
        check("R7 abort single", abort_rd, 0);

        // R8: protected sector only -> empty batch, no start
        prot_mask = 8'h08;
        wr(3, 8'h30, 1); tick();
        check("R8 protected not queued", pend_mask, 0);
        check("R8 window opened", win_open, 1);
        begin
            bit saw = 0;
            for (int i = 0; i < WIN; i++) begin tick(); saw |= erase_start; end
            check("R8 no start on empty", saw, 0);
            check("R8 back to idle", win_open | erase_begun, 0);
        end
        prot_mask = 8'h02;
        wr(1, 8'h30, 1); tick();
        wr(4, 8'h30, 0); tick();
        check("R8 partial protect", pend_mask, 8'h10);
        finish_erase();

        // R4: all eight in reverse order with a repeat
        prot_mask = 0;
        wr(7, 8'h30, 1); tick();
        for (int s = 6; s >= 0; s--) begin wr(s, 8'h30, 0); tick(); end
        wr(3, 8'h30, 0); tick();
        check("R4 all eight", pend_mask, 8'hFF);
        finish_erase();

        // random traffic against the model
        for (int blk = 0; blk < 6; blk++) begin
            prot_mask = 8'($urandom);
            for (int c = 0; c < 600; c++) begin
                int r = $urandom_range(0, 99);
                if (r < 30) begin
                    wr_stb   = 1;
                    wr_addr  = 17'($urandom);
                    wr_data  = ($urandom_range(0, 9) < 8) ? 8'h30 : 8'($urandom);
                    seq_done = ($urandom_range(0, 3) == 0);
                end
                erase_done = ($urandom_range(0, 19) == 0);
                tick();
            end
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule